// File: doc/BRIEF.md
# Multi-Mode Timer Waveform Generator

This block is a timer-counter core with four compare channels. A single counter serves eight waveform modes, chosen by a 3-bit mode input. Modes 0 to 3 count in one direction and wrap. Modes 4 to 7 count up to the top value and back down to zero. Each compare channel drives one waveform pin. On a compare match the pin toggles, is set to a level, or is cleared to a level, depending on the mode, the count direction and the channel's polarity bit.

The period and the four compare values are each held as an active register plus a buffered copy. Software-side writes go only to the buffered copy and set a pending flag. The active register takes the new value only at the update point of the current mode. That point is a fixed position on the count waveform, so a new period or duty cycle never takes effect in the middle of a cycle. Any register can be put in circular mode. Each update then swaps the active and buffered values, so the register alternates between two settings without any write.

The block has three status outputs. The update strobe marks the update point. The event pulse marks the overflow or underflow point of the mode. The count value is also driven out so the waveform phase can be observed.

Top module: `wavegen_tc`

## Requirements
- R1: After synchronous reset the count is 0, all four waveform pins are 0, the update strobe and the event pulse are 0, all active and buffered values are 0, and no buffered load is pending.
- R2: In modes 0 to 3 with `dir_cfg`=0 the counter runs 0,1,…,TOP and then returns to 0. With `dir_cfg`=1 it runs TOP,…,1,0 and then reloads TOP. TOP is the active value of channel 0 in mode 1 and the active period in every other mode.
- R3: In modes 0 to 3, `upd_o` and `evt_o` are both high for exactly the one cycle in which the count equals TOP (when counting up) or 0 (when counting down).
- R4: In modes 0 and 1 a channel pin inverts in the cycle after the cycle whose count equals that channel's active compare value, and at no other time. The update point does not change it.
- R5: In modes 2 and 3 the update point drives a pin to its start level, and a compare match drives it to the opposite level; if both happen in the same cycle the start level wins. The start level is the inverse of the direction bit (1 = counting down) when polarity is 0, and the direction bit itself when polarity is 1. Counting up, the pin is at its start level while count ≤ compare value. Counting down, it is at its start level while count ≥ compare value.
- R6: In modes 4 to 7 the counter rises from 0 to TOP and falls back to 0. The direction reverses automatically at TOP and at 0, and `dir_cfg` is ignored.
- R7: In modes 4 to 7 a compare match drives the pin to the inverse of the current direction (polarity 0) or to the direction itself (polarity 1). For polarity 0 and 0 < compare < TOP, the pin is high while rising with count > compare, and while falling with count ≥ compare.
- R8: In modes 4 to 7 the update point and the event point are as follows:
  - Modes 4 and 5: update at 0, event at 0.
  - Mode 6: update at TOP and at 0, event at TOP and at 0.
  - Mode 7: update at 0, event at TOP.
- R9: A buffered write leaves the active value unchanged until the next update point. The active value is then loaded if a write is pending, and the pending flag clears. With no new write, later updates leave the active value alone.
- R10: With `circ_per_en`=1, every update point swaps the active and buffered period, so successive cycles alternate between the two TOP values.
- R11: With `circ_cc_en[i]`=1, every update point swaps channel i's active and buffered compare values. Other channels are unaffected.
- R12: While `run`=0 the count and the pins hold their values, and `upd_o` and `evt_o` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Count enable |
| mode | input | 3 | Waveform mode select (0..7) |
| dir_cfg | input | 1 | Count direction in modes 0 to 3 (1 = down) |
| pol | input | 4 | Per-channel polarity |
| circ_cc_en | input | 4 | Per-channel circular compare enable |
| circ_per_en | input | 1 | Circular period enable |
| per_wr | input | 1 | Write strobe for the buffered period |
| per_din | input | 16 | Buffered period write data |
| cc_wr | input | 4 | Per-channel write strobes for the buffered compare values |
| cc_din | input | 64 | Buffered compare write data, channel i in bits 16i+15:16i |
| wave_o | output | 4 | Waveform pins |
| evt_o | output | 1 | Overflow/underflow event pulse |
| upd_o | output | 1 | Update strobe |
| count_o | output | 16 | Current count |

## Verification
A wrong direction bit shows up on the count within one cycle: a rising sequence turns into a falling one, or the count runs past TOP. In modes 4 to 7 it also inverts the level that the next compare match drives. A stale or lost pending flag shows as a count maximum or a pin duty cycle that is wrong for an entire waveform cycle, starting at the first update point after the write. A broken circular swap shows as two consecutive cycles with equal length where alternating lengths are expected. The bench therefore compares each sampled cycle against the count-position formulas and measures per-cycle maxima and high times across several consecutive waveform cycles.

// File: rtl/wg_pkg.sv
package wg_pkg;

    // Waveform mode codes; bit 2 selects up/down (triangle) counting.
    typedef enum logic [2:0] {
        WM_FREQ_TOGGLE = 3'd0,
        WM_FREQ_CC0TOP = 3'd1,
        WM_PWM_SINGLE  = 3'd2,
        WM_PWM_DUALCMP = 3'd3,
        WM_TRI_CRIT    = 3'd4,
        WM_TRI_LOW     = 3'd5,
        WM_TRI_ENDS    = 3'd6,
        WM_TRI_HIGH    = 3'd7
    } wave_mode_e;

    // Turning points of the count waveform in the current cycle.
    typedef struct packed {
        logic hit_top;
        logic hit_zero;
        logic dir;
    } turn_pts_t;

    function automatic logic mode_is_tri(wave_mode_e m);
        return (m == WM_TRI_CRIT) || (m == WM_TRI_LOW) ||
               (m == WM_TRI_ENDS) || (m == WM_TRI_HIGH);
    endfunction

    function automatic logic mode_is_freq(wave_mode_e m);
        return (m == WM_FREQ_TOGGLE) || (m == WM_FREQ_CC0TOP);
    endfunction

    // Update at zero applies to every mode; at top only single-slope and both-ends.
    function automatic logic upd_on_top(wave_mode_e m);
        return !mode_is_tri(m) || (m == WM_TRI_ENDS);
    endfunction

    function automatic logic evt_on_top(wave_mode_e m);
        return !mode_is_tri(m) || (m == WM_TRI_ENDS) || (m == WM_TRI_HIGH);
    endfunction

    function automatic logic evt_on_zero(wave_mode_e m);
        return m != WM_TRI_HIGH;
    endfunction

endpackage

// File: rtl/wg_counter.sv
module wg_counter
    import wg_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            run,
    input  wave_mode_e      mode,
    input  logic            dir_cfg,
    input  logic [CW-1:0]   top,
    output logic [CW-1:0]   count,
    output turn_pts_t       pts,
    output logic            upd,
    output logic            evt
);
    localparam logic [CW-1:0] ONE = CW'(1);

    logic [CW-1:0] cnt_q, cnt_d;
    logic          dir_q, dir_d;
    logic          tri_m, dir_eff, at_top, at_zero;

    always_comb begin
        tri_m   = mode_is_tri(mode);
        dir_eff = tri_m ? dir_q : dir_cfg;
        at_top  = !dir_eff && (cnt_q >= top);
        at_zero = dir_eff && (cnt_q == '0);
        pts     = '{hit_top: at_top, hit_zero: at_zero, dir: dir_eff};
        upd     = run && ((at_top && upd_on_top(mode)) || at_zero);
        evt     = run && ((at_top && evt_on_top(mode)) ||
                          (at_zero && evt_on_zero(mode)));
    end

    always_comb begin
        cnt_d = cnt_q;
        dir_d = tri_m ? dir_q : dir_cfg;
        if (run) begin
            if (!tri_m) begin
                if (!dir_eff) cnt_d = at_top ? '0 : cnt_q + ONE;
                else          cnt_d = at_zero ? top : cnt_q - ONE;
            end else if (at_top) begin
                dir_d = 1'b1;
                cnt_d = (cnt_q == '0) ? '0 : cnt_q - ONE;
            end else if (at_zero) begin
                dir_d = 1'b0;
                cnt_d = (top == '0) ? '0 : ONE;
            end else begin
                cnt_d = dir_eff ? cnt_q - ONE : cnt_q + ONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            dir_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            dir_q <= dir_d;
        end
    end

    assign count = cnt_q;

endmodule

// File: rtl/wg_bufreg.sv
module wg_bufreg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [W-1:0] din,
    input  logic         upd,
    input  logic         circ,
    output logic [W-1:0] act
);
    logic [W-1:0] act_q, hold_q;
    logic         pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q  <= '0;
            hold_q <= '0;
            pend_q <= 1'b0;
        end else begin
            // Active side: swap in circular mode, pending load otherwise.
            if (upd && (circ || pend_q)) act_q <= hold_q;
            // Buffer side: a fresh write always wins over the copy-back.
            if (wr) begin
                hold_q <= din;
                pend_q <= 1'b1;
            end else if (upd && circ) begin
                hold_q <= act_q;
                pend_q <= 1'b0;
            end else if (upd) begin
                pend_q <= 1'b0;
            end
        end
    end

    assign act = act_q;

endmodule

// File: rtl/wg_channel.sv
module wg_channel
    import wg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  wave_mode_e mode,
    input  logic       dir,
    input  logic       pol,
    input  logic       match,
    input  logic       upd,
    output logic       wave
);
    // Level for cycle start (single-slope) and for a match (dual-slope).
    logic lvl_a;
    assign lvl_a = pol ? dir : !dir;

    always_ff @(posedge clk) begin
        if (rst) begin
            wave <= 1'b0;
        end else if (run) begin
            if (mode_is_freq(mode)) begin
                if (match) wave <= !wave;
            end else if (!mode_is_tri(mode)) begin
                if (upd)        wave <= lvl_a;
                else if (match) wave <= !lvl_a;
            end else if (match) begin
                wave <= lvl_a;
            end
        end
    end

endmodule

// File: rtl/wavegen_tc.sv
module wavegen_tc
    import wg_pkg::*;
#(
    parameter int CW  = 16,
    parameter int NCH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [2:0]        mode,
    input  logic              dir_cfg,
    input  logic [NCH-1:0]    pol,
    input  logic [NCH-1:0]    circ_cc_en,
    input  logic              circ_per_en,
    input  logic              per_wr,
    input  logic [CW-1:0]     per_din,
    input  logic [NCH-1:0]    cc_wr,
    input  logic [NCH*CW-1:0] cc_din,
    output logic [NCH-1:0]    wave_o,
    output logic              evt_o,
    output logic              upd_o,
    output logic [CW-1:0]     count_o
);
    wave_mode_e                mode_e;
    logic [CW-1:0]             per_act, top_val, cnt;
    logic [NCH-1:0][CW-1:0]    cc_act;
    turn_pts_t                 pts;
    logic                      upd, evt;

    assign mode_e  = wave_mode_e'(mode);
    assign top_val = (mode_e == WM_FREQ_CC0TOP) ? cc_act[0] : per_act;

    wg_counter #(.CW(CW)) u_cnt (
        .clk(clk), .rst(rst), .run(run), .mode(mode_e), .dir_cfg(dir_cfg),
        .top(top_val), .count(cnt), .pts(pts), .upd(upd), .evt(evt)
    );

    wg_bufreg #(.W(CW)) u_per (
        .clk(clk), .rst(rst), .wr(per_wr), .din(per_din), .upd(upd),
        .circ(circ_per_en), .act(per_act)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        wg_bufreg #(.W(CW)) u_cc (
            .clk(clk), .rst(rst), .wr(cc_wr[i]), .din(cc_din[i*CW +: CW]),
            .upd(upd), .circ(circ_cc_en[i]), .act(cc_act[i])
        );
        wg_channel u_wave (
            .clk(clk), .rst(rst), .run(run), .mode(mode_e), .dir(pts.dir),
            .pol(pol[i]), .match(cnt == cc_act[i]), .upd(upd), .wave(wave_o[i])
        );
    end

    assign evt_o   = evt;
    assign upd_o   = upd;
    assign count_o = cnt;

endmodule

// File: rtl/wavegen_tc_chk.sv
module wavegen_tc_chk #(
    parameter int CW  = 16,
    parameter int NCH = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              run,
    input logic [2:0]        mode,
    input logic              dir_cfg,
    input logic [NCH-1:0]    wave_o,
    input logic              evt_o,
    input logic              upd_o,
    input logic [CW-1:0]     count_o,
    input logic [NCH*CW-1:0] cc_flat
);
    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        !run |-> (!upd_o && !evt_o));

    p_idle_hold_r12: assert property (@(posedge clk) disable iff (rst)
        !run |=> ($stable(count_o) && $stable(wave_o)));

    p_single_evt_r3: assert property (@(posedge clk) disable iff (rst)
        (run && !mode[2]) |-> (evt_o == upd_o));

    p_tri_evt_r8: assert property (@(posedge clk) disable iff (rst)
        (run && mode[2] && mode != 3'd7) |-> (evt_o == upd_o));

    p_up_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        (run && !mode[2] && !dir_cfg && upd_o) |=> (count_o == '0));

    for (genvar i = 0; i < NCH; i++) begin : g_chk
        p_freq_quiet_r4: assert property (@(posedge clk) disable iff (rst)
            (run && mode[2:1] == 2'b00 && count_o != cc_flat[i*CW +: CW])
            |=> $stable(wave_o[i]));
    end

endmodule

bind wavegen_tc wavegen_tc_chk #(.CW(CW), .NCH(NCH)) u_chk (
    .clk(clk), .rst(rst), .run(run), .mode(mode), .dir_cfg(dir_cfg),
    .wave_o(wave_o), .evt_o(evt_o), .upd_o(upd_o), .count_o(count_o),
    .cc_flat(cc_act)
);

// File: tb/wavegen_tc_test.sv
`timescale 1ns/1ps
module wavegen_tc_test;
    localparam int CW = 16;
    localparam real HALF = 2.5;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            run = 1'b0;
    logic [2:0]      mode = 3'd0;
    logic            dir_cfg = 1'b0;
    logic [3:0]      pol = 4'h0;
    logic [3:0]      circ_cc_en = 4'h0;
    logic            circ_per_en = 1'b0;
    logic            per_wr = 1'b0;
    logic [CW-1:0]   per_din = '0;
    logic [3:0]      cc_wr = 4'h0;
    logic [4*CW-1:0] cc_din = '0;
    logic [3:0]      wave_o;
    logic            evt_o, upd_o;
    logic [CW-1:0]   count_o;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    always #(HALF) clk = ~clk;

    wavegen_tc uut (
        .clk(clk), .rst(rst), .run(run), .mode(mode), .dir_cfg(dir_cfg),
        .pol(pol), .circ_cc_en(circ_cc_en), .circ_per_en(circ_per_en),
        .per_wr(per_wr), .per_din(per_din), .cc_wr(cc_wr), .cc_din(cc_din),
        .wave_o(wave_o), .evt_o(evt_o), .upd_o(upd_o), .count_o(count_o)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(bit ok, string req, string what, int act, int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic setup(int m, bit dc, logic [3:0] pv, int per,
                         int c0, int c1, int c2, int c3, int warm);
        rst = 1'b1; run = 1'b0; per_wr = 1'b0; cc_wr = 4'h0;
        circ_cc_en = 4'h0; circ_per_en = 1'b0;
        mode = 3'(m); dir_cfg = dc; pol = pv;
        step(); step();
        rst = 1'b0; run = 1'b1;
        per_wr = 1'b1; per_din = CW'(per);
        cc_wr = 4'hF; cc_din = {CW'(c3), CW'(c2), CW'(c1), CW'(c0)};
        step();
        per_wr = 1'b0; cc_wr = 4'h0;
        repeat (warm) step();
    endtask

    task automatic measure_up(output int mx);
        mx = int'(count_o);
        for (int k = 0; k < 1000; k++) begin
            step();
            if (count_o == '0) break;
            if (int'(count_o) > mx) mx = int'(count_o);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1; run = 1'b0; mode = 3'd0;
        step(); step();
        rst = 1'b0;
        step();
        chk(count_o == '0, "R1", "count after reset", int'(count_o), 0);
        chk(wave_o == 4'h0, "R1", "pins after reset", int'(wave_o), 0);
        chk(upd_o == 1'b0 && evt_o == 1'b0, "R1", "strobes after reset",
            int'({upd_o, evt_o}), 0);
    endtask

    task automatic t_freq_normal();
        int cc[4] = '{3, 7, 12, 0};
        int top = 9;
        int e_cnt = 0, e_pt = 0, e_tog = 0, ntog = 0;
        int pc; logic [3:0] pw;
        setup(0, 1'b0, 4'h0, top, cc[0], cc[1], cc[2], cc[3], 25);
        pc = int'(count_o); pw = wave_o;
        for (int t = 0; t < 40; t++) begin
            step();
            if (int'(count_o) != ((pc == top) ? 0 : pc + 1)) e_cnt++;
            if (upd_o != (int'(count_o) == top) || evt_o != upd_o) e_pt++;
            for (int i = 0; i < 4; i++) begin
                if ((wave_o[i] != pw[i]) != (pc == cc[i])) e_tog++;
                if (wave_o[i] != pw[i]) ntog++;
            end
            pc = int'(count_o); pw = wave_o;
        end
        chk(e_cnt == 0, "R2", "up count sequence mode 0", e_cnt, 0);
        chk(e_pt == 0, "R3", "update/event at TOP mode 0", e_pt, 0);
        chk(e_tog == 0, "R4", "toggle on match mode 0", e_tog, 0);
        chk(ntog == 12, "R4", "toggle total over 4 periods", ntog, 12);
    endtask

    task automatic t_freq_match();
        int top = 6;
        int e_cnt = 0, e_tog = 0;
        int pc; logic [3:0] pw;
        setup(1, 1'b0, 4'h0, 20, top, 2, 30, 30, 20);
        pc = int'(count_o); pw = wave_o;
        for (int t = 0; t < 28; t++) begin
            step();
            if (int'(count_o) != ((pc == top) ? 0 : pc + 1)) e_cnt++;
            if ((wave_o[0] != pw[0]) != (pc == top)) e_tog++;
            if ((wave_o[1] != pw[1]) != (pc == 2)) e_tog++;
            if (wave_o[3:2] != pw[3:2]) e_tog++;
            pc = int'(count_o); pw = wave_o;
        end
        chk(e_cnt == 0, "R2", "mode 1 top from channel 0", e_cnt, 0);
        chk(e_tog == 0, "R4", "mode 1 toggles", e_tog, 0);
    endtask

    task automatic t_pwm_up();
        int cc[4] = '{0, 2, 5, 9};
        int top = 9;
        int e_w = 0;
        setup(2, 1'b0, 4'b0010, top, cc[0], cc[1], cc[2], cc[3], 25);
        for (int t = 0; t < 30; t++) begin
            step();
            for (int i = 0; i < 4; i++) begin
                logic st, ex;
                st = pol[i] ? 1'b0 : 1'b1;
                ex = (int'(count_o) <= cc[i]) ? st : !st;
                if (wave_o[i] != ex) e_w++;
            end
        end
        chk(e_w == 0, "R5", "single-slope PWM up, both polarities", e_w, 0);
    endtask

    task automatic t_pwm_down();
        int cc[4] = '{0, 6, 4, 1};
        int top = 8;
        int e_w = 0, e_cnt = 0, e_pt = 0;
        int pc;
        setup(3, 1'b1, 4'b0100, top, cc[0], cc[1], cc[2], cc[3], 25);
        pc = int'(count_o);
        for (int t = 0; t < 27; t++) begin
            step();
            if (int'(count_o) != ((pc == 0) ? top : pc - 1)) e_cnt++;
            if (upd_o != (count_o == '0) || evt_o != upd_o) e_pt++;
            for (int i = 0; i < 4; i++) begin
                logic st, ex;
                st = pol[i] ? 1'b1 : 1'b0;
                ex = (int'(count_o) >= cc[i]) ? st : !st;
                if (wave_o[i] != ex) e_w++;
            end
            pc = int'(count_o);
        end
        chk(e_cnt == 0, "R2", "down count sequence", e_cnt, 0);
        chk(e_pt == 0, "R3", "update/event at zero counting down", e_pt, 0);
        chk(e_w == 0, "R5", "mode 3 PWM counting down", e_w, 0);
    endtask

    task automatic t_dual();
        int cc[4] = '{2, 5, 3, 6};
        int top = 8;
        int e_cnt = 0, e_w = 0, e_pt = 0;
        int ec = 0; bit ed = 1'b1;
        setup(6, 1'b1, 4'b1010, top, cc[0], cc[1], cc[2], cc[3], 40);
        for (int k = 0; k < 40 && count_o != '0; k++) step();
        for (int t = 0; t < 48; t++) begin
            if (int'(count_o) != ec) e_cnt++;
            if (upd_o != (ec == 0 || ec == top) || evt_o != upd_o) e_pt++;
            for (int i = 0; i < 4; i++) begin
                logic hi;
                hi = ed ? (ec >= cc[i]) : (ec > cc[i]);
                if (pol[i]) hi = !hi;
                if (wave_o[i] != hi) e_w++;
            end
            if (ed && ec == 0)          begin ed = 1'b0; ec = 1; end
            else if (!ed && ec == top)  begin ed = 1'b1; ec = top - 1; end
            else                        ec = ed ? ec - 1 : ec + 1;
            step();
        end
        chk(e_cnt == 0, "R6", "triangle count ignores dir_cfg", e_cnt, 0);
        chk(e_w == 0, "R7", "dual-slope pins both polarities", e_w, 0);
        chk(e_pt == 0, "R8", "mode 6 update/event at both ends", e_pt, 0);
    endtask

    task automatic t_dual_modes();
        int top = 5;
        int mlist[3] = '{4, 5, 7};
        foreach (mlist[j]) begin
            int e_u = 0, e_e = 0, nev = 0;
            setup(mlist[j], 1'b0, 4'h0, top, 1, 2, 3, 4, 20);
            for (int t = 0; t < 30; t++) begin
                step();
                if (upd_o != (count_o == '0)) e_u++;
                if (mlist[j] == 7) begin
                    if (evt_o != (int'(count_o) == top)) e_e++;
                end else begin
                    if (evt_o != (count_o == '0)) e_e++;
                end
                if (evt_o) nev++;
            end
            chk(e_u == 0, "R8", $sformatf("mode %0d update at zero", mlist[j]), e_u, 0);
            chk(e_e == 0 && nev == 3, "R8", $sformatf("mode %0d event points", mlist[j]), nev, 3);
        end
    endtask

    task automatic t_buffer();
        int m1, m2, m3;
        setup(2, 1'b0, 4'h0, 5, 1, 1, 1, 1, 15);
        for (int k = 0; k < 20 && count_o != CW'(2); k++) step();
        per_wr = 1'b1; per_din = CW'(9);
        step();
        per_wr = 1'b0;
        measure_up(m1);
        measure_up(m2);
        measure_up(m3);
        chk(m1 == 5, "R9", "old period kept until update", m1, 5);
        chk(m2 == 9, "R9", "new period after update", m2, 9);
        chk(m3 == 9, "R9", "period held without new write", m3, 9);
    endtask

    task automatic t_circ_per();
        int mx[4];
        int exp4[4] = '{4, 7, 4, 7};
        setup(0, 1'b0, 4'h0, 4, 9, 9, 9, 9, 12);
        for (int k = 0; k < 20 && count_o != CW'(1); k++) step();
        circ_per_en = 1'b1;
        per_wr = 1'b1; per_din = CW'(7);
        step();
        per_wr = 1'b0;
        for (int p = 0; p < 4; p++) measure_up(mx[p]);
        for (int p = 0; p < 4; p++)
            chk(mx[p] == exp4[p], "R10", $sformatf("circular period cycle %0d", p),
                mx[p], exp4[p]);
    endtask

    task automatic t_circ_cc();
        int exp3[3] = '{7, 4, 7};
        setup(2, 1'b0, 4'h0, 9, 0, 3, 0, 0, 25);
        for (int k = 0; k < 20 && count_o != CW'(1); k++) step();
        circ_cc_en = 4'b0010;
        cc_wr = 4'b0010; cc_din = {CW'(0), CW'(0), CW'(6), CW'(0)};
        step();
        cc_wr = 4'h0;
        for (int k = 0; k < 20 && count_o != '0; k++) step();
        for (int p = 0; p < 3; p++) begin
            int h1 = 0, h0 = 0;
            for (int t = 0; t < 10; t++) begin
                if (wave_o[1]) h1++;
                if (wave_o[0]) h0++;
                step();
            end
            chk(h1 == exp3[p], "R11", $sformatf("circular compare high time %0d", p),
                h1, exp3[p]);
            chk(h0 == 1, "R11", "non-circular channel unchanged", h0, 1);
        end
    endtask

    task automatic t_hold();
        logic [CW-1:0] c0; logic [3:0] w0;
        int e_h = 0, e_s = 0;
        setup(0, 1'b0, 4'h0, 7, 2, 3, 4, 5, 13);
        run = 1'b0;
        step();
        c0 = count_o; w0 = wave_o;
        for (int t = 0; t < 10; t++) begin
            step();
            if (count_o != c0 || wave_o != w0) e_h++;
            if (upd_o || evt_o) e_s++;
        end
        chk(e_h == 0, "R12", "count and pins frozen", e_h, 0);
        chk(e_s == 0, "R12", "no strobes while stopped", e_s, 0);
        run = 1'b1;
        step();
        chk(count_o != c0, "R12", "count resumes", int'(count_o), int'(c0) + 1);
    endtask

    initial begin
        #(200000 * 2 * HALF);
        if (!done) begin
            nchk++; nerr++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_freq_normal();
        t_freq_match();
        t_pwm_up();
        t_pwm_down();
        t_dual();
        t_dual_modes();
        t_buffer();
        t_circ_per();
        t_circ_cc();
        t_hold();
        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule